// File: doc/BRIEF.md
# Prescaled Machine Timer with Compare Interrupt

A machine-mode timer for one hart. A prescaler cuts the clock into ticks, and on every tick a 64-bit time counter grows by a programmable increment. When the counter is at or above a 64-bit compare value, a sticky status bit is set. The interrupt line is that status bit gated by an enable bit.

Software reaches the timer through a small word bus with byte enables. A request is accepted in any cycle, and its response comes back on the next cycle. Software can rewrite the counter or the compare value while the timer runs, to move an expiry. Software can also inject the interrupt through a test register.

Top module: `tick_timer`

## Requirements
- R1: After reset: run bit 0, enable 0, status 0, time 0, config 0, compare all ones (both words), `irq_o` low and `rsp_valid_o` low.
- R2: The config word at 0x10 holds the divider in bits [11:0] and the increment in bits [23:16]. While running, the time counter grows by the increment once every (divider+1) clocks.
- R3: While the run bit (0x00 bit 0) is 0, the time counter holds its value and an expiry does not set the status bit.
- R4: While running, the status bit (0x08 bit 0) is set on the clock edge after time ≥ compare. It stays set until software clears it.
- R5: `irq_o` is high exactly when the status bit and the enable bit (0x04 bit 0) are both 1.
- R6: Writing 1 to bit 0 of 0x08 clears the status bit. A set event in the same cycle wins over the clear.
- R7: Writing 1 to bit 0 of the test word 0x0C sets the status bit, whether or not the timer runs. The test word reads as 0.
- R8: Writes to time (0x14 low, 0x18 high) or to compare (0x1C low, 0x20 high) take effect at once. If either is moved past the pending expiry before it is reached, no status is raised.
- R9: A write to either time word restarts the divider count at zero.
- R10: A write changes only the bytes whose `req_be_i` bit is set. A read returns the whole 32-bit word whatever the byte enables are.
- R11: An access to any other address, or to an address that is not word aligned, returns `rsp_err_o` = 1 with read data 0 and changes no register.
- R12: Every request gets exactly one `rsp_valid_o` pulse on the following cycle. A read returns the register contents from before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables for writes |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Unmapped or misaligned access |
| irq_o | output | 1 | Timer interrupt |

## Verification
The bench builds the timer with its default widths: a 6-bit address, a 12-bit divider and an 8-bit increment. The random runs use small dividers of 0 to 7 and short run windows. This lets many ticks, and expiries on both sides of the compare value, happen within a few dozen cycles. Directed cases cover the following, all at small counts where the exact tick edge can be predicted:
- moving compare away one cycle before expiry,
- the divider restart on a time write,
- partial byte writes,
- unmapped addresses.

// File: rtl/tick_timer_pkg.sv
// Package: shared widths, register offsets and the byte-merge helper.
// Assumes a 32-bit bus word and a 64-bit time base split into two words.
package tick_timer_pkg;
    localparam int WORD_W  = 32;
    localparam int BE_W    = WORD_W / 8;
    localparam int TIME_W  = 2 * WORD_W;

    localparam logic [7:0] OFS_RUN    = 8'h00;
    localparam logic [7:0] OFS_ENABLE = 8'h04;
    localparam logic [7:0] OFS_STATUS = 8'h08;
    localparam logic [7:0] OFS_TEST   = 8'h0C;
    localparam logic [7:0] OFS_CFG    = 8'h10;
    localparam logic [7:0] OFS_TIME_L = 8'h14;
    localparam logic [7:0] OFS_TIME_H = 8'h18;
    localparam logic [7:0] OFS_CMP_L  = 8'h1C;
    localparam logic [7:0] OFS_CMP_H  = 8'h20;

    // Replace only the enabled bytes of old_w with those of new_w.
    function automatic logic [WORD_W-1:0] be_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0]   be);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < BE_W; b++) begin
            r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/tt_prescaler.sv
// Divider: emits a one-cycle tick every (limit+1) running clocks.
// Assumes restart has priority and that the count holds while stopped.
module tt_prescaler #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    // Tick when the running count has reached the limit.
    assign tick_o = run_i && (cnt_q == limit_i);

    // Count running clocks, wrap on tick, restart on request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (restart_i)  cnt_q <= '0;
        else if (tick_o)     cnt_q <= '0;
        else if (run_i)      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tt_counter.sv
// Time base: 64-bit counter that adds the step on each tick and accepts
// word writes with byte enables. Flags time >= compare.
// Assumes a software write wins over a tick in the same cycle.
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [TIME_W-1:0] cmp_i,
    output logic [TIME_W-1:0] time_o,
    output logic              expired_o
);
    logic [TIME_W-1:0] time_q;

    assign time_o    = time_q;
    assign expired_o = (time_q >= cmp_i);

    // Load from software or advance by the step on a tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            time_q <= '0;
        end else if (wr_lo_i) begin
            time_q[WORD_W-1:0] <= be_merge(time_q[WORD_W-1:0], wdata_i, be_i);
        end else if (wr_hi_i) begin
            time_q[TIME_W-1:WORD_W] <= be_merge(time_q[TIME_W-1:WORD_W], wdata_i, be_i);
        end else if (tick_i) begin
            time_q <= time_q + TIME_W'(step_i);
        end
    end
endmodule

// File: rtl/tt_csr.sv
// Register file: decodes the word bus, holds the run, enable, status,
// config and compare registers, and returns one response per request.
// Assumes one request per cycle and a response on the next cycle.
module tt_csr
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 12,
    parameter int STEP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [WORD_W-1:0] req_wdata_i,
    input  logic [BE_W-1:0]   req_be_i,
    output logic              rsp_valid_o,
    output logic [WORD_W-1:0] rsp_rdata_o,
    output logic              rsp_err_o,
    input  logic [TIME_W-1:0] time_i,
    input  logic              expired_i,
    output logic              run_o,
    output logic              enable_o,
    output logic              status_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [STEP_W-1:0] step_o,
    output logic [TIME_W-1:0] cmp_o,
    output logic              time_wr_lo_o,
    output logic              time_wr_hi_o
);
    localparam int STEP_LSB = 16;

    logic              run_q, enable_q, status_q;
    logic [WORD_W-1:0] cfg_q;
    logic [TIME_W-1:0] cmp_q;
    logic [7:0]        ofs;
    logic              hit_run, hit_en, hit_st, hit_test, hit_cfg;
    logic              hit_tl, hit_th, hit_cl, hit_ch, mapped;
    logic              wr, set_evt, clr_evt;
    logic [WORD_W-1:0] rd_word;

    // Widen the address to the offset width used by the map.
    assign ofs      = 8'(req_addr_i);
    assign hit_run  = (ofs == OFS_RUN);
    assign hit_en   = (ofs == OFS_ENABLE);
    assign hit_st   = (ofs == OFS_STATUS);
    assign hit_test = (ofs == OFS_TEST);
    assign hit_cfg  = (ofs == OFS_CFG);
    assign hit_tl   = (ofs == OFS_TIME_L);
    assign hit_th   = (ofs == OFS_TIME_H);
    assign hit_cl   = (ofs == OFS_CMP_L);
    assign hit_ch   = (ofs == OFS_CMP_H);
    assign mapped   = hit_run | hit_en | hit_st | hit_test | hit_cfg
                    | hit_tl | hit_th | hit_cl | hit_ch;
    assign wr       = req_valid_i && req_write_i && mapped;

    assign time_wr_lo_o = wr && hit_tl;
    assign time_wr_hi_o = wr && hit_th;

    assign set_evt = (run_q && expired_i) || (wr && hit_test && req_be_i[0] && req_wdata_i[0]);
    assign clr_evt = wr && hit_st && req_be_i[0] && req_wdata_i[0];

    assign run_o    = run_q;
    assign enable_o = enable_q;
    assign status_o = status_q;
    assign div_o    = cfg_q[DIV_W-1:0];
    assign step_o   = cfg_q[STEP_LSB +: STEP_W];
    assign cmp_o    = cmp_q;

    // Select the word returned for a read of the current address.
    always_comb begin
        rd_word = '0;
        if (hit_run) rd_word[0] = run_q;
        if (hit_en)  rd_word[0] = enable_q;
        if (hit_st)  rd_word[0] = status_q;
        if (hit_cfg) rd_word    = cfg_q;
        if (hit_tl)  rd_word    = time_i[WORD_W-1:0];
        if (hit_th)  rd_word    = time_i[TIME_W-1:WORD_W];
        if (hit_cl)  rd_word    = cmp_q[WORD_W-1:0];
        if (hit_ch)  rd_word    = cmp_q[TIME_W-1:WORD_W];
    end

    // Control, enable and config registers with byte-enable writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q    <= 1'b0;
            enable_q <= 1'b0;
            cfg_q    <= '0;
        end else if (wr) begin
            if (hit_run && req_be_i[0]) run_q    <= req_wdata_i[0];
            if (hit_en  && req_be_i[0]) enable_q <= req_wdata_i[0];
            if (hit_cfg) cfg_q <= be_merge(cfg_q, req_wdata_i, req_be_i)
                                  & {{(WORD_W-STEP_LSB-STEP_W){1'b0}}, {STEP_W{1'b1}},
                                     {(STEP_LSB-DIV_W){1'b0}}, {DIV_W{1'b1}}};
        end
    end

    // Compare value, reset to all ones so nothing expires by default.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q <= '1;
        end else if (wr && hit_cl) begin
            cmp_q[WORD_W-1:0] <= be_merge(cmp_q[WORD_W-1:0], req_wdata_i, req_be_i);
        end else if (wr && hit_ch) begin
            cmp_q[TIME_W-1:WORD_W] <= be_merge(cmp_q[TIME_W-1:WORD_W], req_wdata_i, req_be_i);
        end
    end

    // Sticky status: set wins over write-one-to-clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      status_q <= 1'b0;
        else if (set_evt) status_q <= 1'b1;
        else if (clr_evt) status_q <= 1'b0;
    end

    // One response per request, on the cycle after it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= req_valid_i && !mapped;
            rsp_rdata_o <= (req_valid_i && !req_write_i && mapped) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/tick_timer.sv
// Top: prescaled 64-bit machine timer with a compare interrupt.
// Assumes a single hart and a single timer; irq_o is combinational from
// the status and enable registers.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 12,
    parameter int STEP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    input  logic [3:0]        req_be_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              rsp_err_o,
    output logic              irq_o
);
    logic              run_w, enable_w, status_w, tick_w, expired_w;
    logic              time_wr_lo_w, time_wr_hi_w, time_wr_w;
    logic [DIV_W-1:0]  div_w;
    logic [STEP_W-1:0] step_w;
    logic [TIME_W-1:0] time_w, cmp_w;

    assign time_wr_w = time_wr_lo_w | time_wr_hi_w;
    assign irq_o     = status_w & enable_w;

    tt_csr #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .STEP_W(STEP_W)) u_csr (
        .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i,
        .req_wdata_i, .req_be_i, .rsp_valid_o, .rsp_rdata_o, .rsp_err_o,
        .time_i(time_w), .expired_i(expired_w), .run_o(run_w),
        .enable_o(enable_w), .status_o(status_w), .div_o(div_w),
        .step_o(step_w), .cmp_o(cmp_w),
        .time_wr_lo_o(time_wr_lo_w), .time_wr_hi_o(time_wr_hi_w)
    );

    tt_prescaler #(.CNT_W(DIV_W)) u_div (
        .clk_i, .rst_ni, .run_i(run_w), .restart_i(time_wr_w),
        .limit_i(div_w), .tick_o(tick_w)
    );

    tt_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk_i, .rst_ni, .tick_i(tick_w), .step_i(step_w),
        .wr_lo_i(time_wr_lo_w), .wr_hi_i(time_wr_hi_w),
        .wdata_i(req_wdata_i), .be_i(req_be_i), .cmp_i(cmp_w),
        .time_o(time_w), .expired_o(expired_w)
    );
endmodule

// File: rtl/tick_timer_chk.sv
// Checker: temporal properties of the timer, bound into tick_timer.
module tick_timer_chk #(
    parameter int ADDR_W = 6,
    parameter int STEP_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [31:0]       req_wdata_i,
    input logic [3:0]        req_be_i,
    input logic              rsp_valid_o,
    input logic              rsp_err_o,
    input logic              irq_o,
    input logic              run_w,
    input logic              tick_w,
    input logic              time_wr_w,
    input logic              status_w,
    input logic              expired_w,
    input logic [STEP_W-1:0] step_w,
    input logic [63:0]       time_w
);
    // R3: a stopped counter holds unless software writes it.
    a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_w && !time_wr_w |=> $stable(time_w));

    // R2: a tick without a write adds the step.
    a_r2_tick_adds_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_w && !time_wr_w |=> time_w == $past(time_w) + 64'($past(step_w)));

    // R4: a running expiry leaves the status set on the next cycle.
    a_r4_expiry_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_w && expired_w |=> status_w);

    // R7: a test-word write of one sets the status.
    a_r7_inject_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && req_write_i && (8'(req_addr_i) == 8'h0C) && req_be_i[0] && req_wdata_i[0]
        |=> status_w);

    // R5: the interrupt never fires without a set status.
    a_r5_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> status_w);

    // R12: each request is answered on the next cycle and only then.
    a_r12_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);
    a_r12_no_stray_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o && !rsp_err_o);

    // R1: outputs are known once out of reset.
    a_r1_known_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown({rsp_valid_o, rsp_err_o, irq_o}));
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .irq_o(irq_o),
    .run_w(run_w), .tick_w(tick_w), .time_wr_w(time_wr_w),
    .status_w(status_w), .expired_w(expired_w), .step_w(step_w),
    .time_w(time_w)
);

// File: tb/tick_timer_tb.sv
// Bench: directed corners plus seeded random runs, checked against
// expected values computed from the requirements.
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid, rsp_err, irq;
    logic [31:0] rsp_rdata;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [31:0] rd;
    logic        er;

    always #5 clk = ~clk;

    tick_timer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
        .req_write_i(req_write), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_be_i(req_be),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .rsp_err_o(rsp_err), .irq_o(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus transaction on one clock edge; samples the response after it.
    task automatic bus(input logic w, input logic [5:0] a, input logic [31:0] d,
                       input logic [3:0] be, output logic [31:0] r, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk); #1;
        r = rsp_rdata; e = rsp_err;
        if (rsp_valid !== 1'b1) check("R12 valid", {63'b0, rsp_valid}, 64'd1);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic [31:0] r; logic e;
        bus(1'b1, a, d, 4'hF, r, e);
    endtask

    task automatic rdw(input logic [5:0] a, output logic [31:0] r);
        logic e;
        bus(1'b0, a, 32'h0, 4'h0, r, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Time after a run of n idle cycles between start and stop writes.
    function automatic logic [63:0] exp_time(input logic [63:0] t0, input int div,
                                             input int step, input int n);
        return t0 + 64'(step) * 64'((n + 1) / (div + 1));
    endfunction

    function automatic logic exp_status(input logic [63:0] t0, input logic [63:0] cmp,
                                        input int div, input int step, input int n);
        return (t0 + 64'(step) * 64'(n / (div + 1))) >= cmp;
    endfunction

    task automatic setup(input int div, input int step, input logic [63:0] t0,
                         input logic [63:0] cmp);
        wr(6'h00, 0);
        wr(6'h08, 1);
        wr(6'h10, (32'(step) << 16) | 32'(div));
        wr(6'h1C, cmp[31:0]);
        wr(6'h20, cmp[63:32]);
        wr(6'h18, t0[63:32]);
        wr(6'h14, t0[31:0]);
    endtask

    task automatic read_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rdw(6'h14, lo); rdw(6'h18, hi);
        t = {hi, lo};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        void'($urandom(32'd1234));
        idle(3);
        #1 rst_n = 1'b1;
        idle(1); #1;

        // R1 reset values
        check("R1 irq", {63'b0, irq}, 0);
        check("R1 rsp_valid", {63'b0, rsp_valid}, 0);
        rdw(6'h00, rd); check("R1 run", rd, 0);
        rdw(6'h08, rd); check("R1 status", rd, 0);
        rdw(6'h1C, rd); check("R1 cmp low", rd, 32'hFFFF_FFFF);
        rdw(6'h20, rd); check("R1 cmp high", rd, 32'hFFFF_FFFF);
        read_time(t);   check("R1 time", t, 0);

        // R2 basic prescaled counting: divider 2, step 5, 11 idle cycles
        setup(2, 5, 64'd0, 64'hFFFF);
        wr(6'h00, 1); idle(11); wr(6'h00, 0);
        read_time(t); check("R2 count", t, exp_time(0, 2, 5, 11));

        // R3 stopped counter holds and no expiry while stopped
        setup(0, 1, 64'd50, 64'd10);
        idle(6);
        read_time(t); check("R3 frozen", t, 64'd50);
        rdw(6'h08, rd); check("R3 no status", rd, 0);

        // R7 inject while stopped, R5 irq gating, R6 clear
        wr(6'h04, 0);
        wr(6'h0C, 1);
        rdw(6'h08, rd); check("R7 inject", rd, 1);
        check("R5 irq gated off", {63'b0, irq}, 0);
        rdw(6'h0C, rd); check("R7 test reads zero", rd, 0);
        wr(6'h04, 1); #1;
        check("R5 irq on", {63'b0, irq}, 1);
        wr(6'h08, 1); #1;
        rdw(6'h08, rd); check("R6 clear", rd, 0);
        check("R5 irq off after clear", {63'b0, irq}, 0);

        // R6 set wins over clear while running and expired
        setup(0, 1, 64'd20, 64'd10);
        wr(6'h00, 1); wr(6'h08, 1); wr(6'h00, 0);
        rdw(6'h08, rd); check("R6 set beats clear", rd, 1);

        // R8 compare moved one cycle before expiry: no status
        setup(0, 1, 64'd0, 64'd10);
        wr(6'h00, 1); idle(9); wr(6'h1C, 1000); idle(5); wr(6'h00, 0);
        rdw(6'h08, rd); check("R8 compare moved", rd, 0);
        // R8 time moved back before expiry: no status
        setup(0, 1, 64'd0, 64'd10);
        wr(6'h00, 1); idle(9); wr(6'h14, 0); idle(5); wr(6'h00, 0);
        rdw(6'h08, rd); check("R8 time moved", rd, 0);
        read_time(t); check("R8 time reload", t, 64'd6);
        // R4 letting it run does expire and status is sticky
        setup(0, 1, 64'd0, 64'd10);
        wr(6'h00, 1); idle(10); wr(6'h00, 0);
        rdw(6'h08, rd); check("R4 expires", rd, 1);
        wr(6'h14, 0);
        rdw(6'h08, rd); check("R4 sticky", rd, 1);

        // R9 time write restarts divider: divider 3, step 1
        setup(3, 1, 64'd0, 64'hFFFF);
        wr(6'h00, 1); idle(1); wr(6'h14, 0); idle(2); wr(6'h00, 0);
        read_time(t); check("R9 restart", t, 64'd0);

        // R10 partial byte write, full-word read
        wr(6'h1C, 32'h1122_3344);
        bus(1'b1, 6'h1C, 32'hAABB_CCDD, 4'b0101, rd, er);
        bus(1'b0, 6'h1C, 32'h0, 4'b0001, rd, er);
        check("R10 byte merge", rd, 32'h11BB_33DD);

        // R11 unmapped and misaligned accesses
        bus(1'b1, 6'h24, 32'h1, 4'hF, rd, er); check("R11 err write", {63'b0, er}, 1);
        bus(1'b1, 6'h01, 32'h1, 4'hF, rd, er); check("R11 err misaligned", {63'b0, er}, 1);
        bus(1'b0, 6'h3C, 32'h0, 4'hF, rd, er); check("R11 err read", {63'b0, er}, 1);
        check("R11 read data zero", rd, 0);
        rdw(6'h00, rd); check("R11 run unchanged", rd, 0);
        rdw(6'h1C, rd); check("R11 cmp unchanged", rd, 32'h11BB_33DD);

        // R2 R4 random runs
        for (int i = 0; i < 24; i++) begin
            int div, step, n, en;
            logic [63:0] t0, cmp;
            div  = $urandom_range(0, 7);
            step = $urandom_range(1, 255);
            n    = $urandom_range(0, 40);
            en   = $urandom_range(0, 1);
            t0   = {24'h0, 8'($urandom_range(0, 3)), $urandom()};
            cmp  = t0 + 64'($urandom_range(0, step * 42 / (div + 1)));
            setup(div, step, t0, cmp);
            wr(6'h04, en);
            wr(6'h00, 1); idle(n); wr(6'h00, 0);
            read_time(t); check("R2 random time", t, exp_time(t0, div, step, n));
            rdw(6'h08, rd); check("R4 random status", rd, {31'b0, exp_status(t0, cmp, div, step, n)});
            #1 check("R5 random irq", {63'b0, irq}, {63'b0, rd[0] & en[0]});
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule